// File: doc/BRIEF.md
# Grouped Peripheral Interrupt Expander

The block gathers up to 96 peripheral interrupt request lines, organised as 12 groups of 8 sources, and reduces them to 12 CPU interrupt lines, one per group. Each source has a flag bit and an enable bit. Each group has an acknowledge bit that gates its CPU line. A single global enable switches the whole mechanism on or off. Software reaches all of this state through a 16-bit register file at fixed word addresses.

When the CPU takes a group interrupt, it presents the group number on the fetch port. In the same cycle the block returns the vector-table word address of the highest-priority pending source in that group. On the next clock edge it clears that source's flag and sets the group's acknowledge bit. A trap port resolves trap numbers into vector addresses without changing any state. Software can raise any source, reserved slots included, by writing its flag bit. The block also qualifies vector-table writes with a protection-unlock input.

Top module: `irq_expander`

## Requirements
- R1: A rising edge on source line n = 8·(g−1) + (i−1) sets flag bit i−1 of group g on the next clock edge, even when that source's enable bit is clear. A line held high sets the flag only once; after software clears the flag, the steady level does not set it again.
- R2: `cpu_irq[g−1]` is high exactly when the global enable is set, group g's acknowledge bit is clear, and group g has at least one bit that is both flagged and enabled. A flagged source whose enable bit is clear never raises the line.
- R3: Within a group, the lowest flagged-and-enabled index wins. While enabled, a fetch for group g (`fetch_grp` = g, 1..12) with a pending winner at index i (1..8) returns `vec_valid`=1 and `vec_addr` = 0xD40 + 0x10·(g−1) + 2·(i−1) in the same cycle.
- R4: An accepted fetch clears the winning flag bit and sets acknowledge bit g−1 on the next clock edge. While that acknowledge bit is set the group's line stays low. It stays set until software writes a 1 to that bit at the acknowledge register; writing 0 there has no effect.
- R5: A write to a flag register stores the written byte into the flags, so writing 1 raises a software interrupt on that source. A read-modify-write therefore clears any flag a peripheral set between the read and the write.
- R6: While enabled and with no fetch in the same cycle, a trap request numbered 1..12 returns `vec_valid`=1 and the group's first vector, 0xD40 + 0x10·(n−1). It changes no flag and no acknowledge bit.
- R7: While enabled, trap number 0 drives `trap_illegal`=1 and `vec_valid`=0.
- R8: With the global enable clear, all CPU lines are low. Fetches and traps return `vec_valid`=0, `trap_illegal`=0 and `vec_addr`=0x000, and leave the flags untouched.
- R9: Register map at word addresses: 0x0CE0 control (bit 0 = global enable); 0x0CE1 acknowledge (bit g−1 for group g, write 1 to clear); 0x0CE2 + 2·(g−1) enable of group g; 0x0CE3 + 2·(g−1) flags of group g. Bit i−1 of the enable and flag registers is index i, and bits 15:8 read 0. Addresses 0x0CFA..0x0CFF read 0 and ignore writes.
- R10: `vt_wr_allow` is high only when `vt_wr_req` and `vt_unlock` are both high. No other register needs a qualifier.
- R11: In groups with no peripheral activity (5, 7, 11), software-raised interrupts on any slot, including reserved ones, raise the group line and fetch the matching vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 96 | Peripheral request lines, bit 8·(g−1)+(i−1) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cpu_irq | output | 12 | Group interrupt lines to the CPU |
| fetch_en | input | 1 | CPU vector fetch for a group |
| fetch_grp | input | 4 | Group number being fetched, 1..12 |
| trap_en | input | 1 | Trap-style vector request |
| trap_num | input | 4 | Trap number |
| vec_addr | output | 12 | Vector-table word address |
| vec_valid | output | 1 | Vector address is meaningful |
| trap_illegal | output | 1 | Trap number has no table entry |
| vt_wr_req | input | 1 | Request to write the vector table |
| vt_unlock | input | 1 | Protection-unlock qualifier |
| vt_wr_allow | output | 1 | Vector-table write permitted |

## Verification
The bench reproduces the read-modify-write hazard. A peripheral edge lands between a flag read and the write-back, and the bench expects that flag to be gone; a design that merged writes as set-only would keep it. It checks that a line held high is captured once and not re-armed after software clears the flag, a fault an edge detector that looks at levels would show. It checks that the acknowledge bit holds the group line low while a second source is still flagged, which catches a design that re-raises the line early or clears acknowledge on a write of 0. Trap 0, traps 1 and 12, the reserved address window, and the disabled state (where a fetch must not consume a flag) cover the edges of the address map and of the decode logic.

// File: rtl/irq_exp_pkg.sv
package irq_exp_pkg;
    localparam int REG_W = 16;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_ACK,
        RK_ENA,
        RK_FLAG
    } reg_kind_e;
endpackage

// File: rtl/irq_exp_group.sv
module irq_exp_group #(
    parameter int GW    = 8,
    parameter int IDX_W = $clog2(GW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GW-1:0]    src_req,
    input  logic             ena_we,
    input  logic             flag_we,
    input  logic [GW-1:0]    wdata,
    input  logic             clr_win,
    output logic [GW-1:0]    ena_o,
    output logic [GW-1:0]    flag_o,
    output logic             pend_o,
    output logic [IDX_W-1:0] win_o
);
    typedef struct packed {
        logic [GW-1:0] src;
        logic [GW-1:0] ena;
        logic [GW-1:0] flag;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [GW-1:0]    rise;
    logic [GW-1:0]    live;
    logic [IDX_W-1:0] win;
    logic [GW-1:0]    base;

    always_comb begin
        live = st_q.flag & st_q.ena;
        win  = '0;
        for (int i = GW - 1; i >= 0; i--) begin
            if (live[i]) win = IDX_W'(i);
        end
        rise      = src_req & ~st_q.src;
        base      = flag_we ? wdata : st_q.flag;
        if (clr_win) base[win] = 1'b0;
        st_d.src  = src_req;
        st_d.ena  = ena_we ? wdata : st_q.ena;
        st_d.flag = base | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena_o  = st_q.ena;
    assign flag_o = st_q.flag;
    assign pend_o = |live;
    assign win_o  = win;

    // R1: every captured edge shows up in the flags one cycle later
    p_edge_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((st_q.flag & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_exp_vector.sv
module irq_exp_vector #(
    parameter int NG         = 12,
    parameter int GW         = 8,
    parameter int IDX_W      = $clog2(GW),
    parameter int GRP_W      = $clog2(NG + 1),
    parameter int VA_W       = 12,
    parameter int VEC_BASE   = 'hD40,
    parameter int VEC_DFLT   = 'h000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      fetch_en,
    input  logic [GRP_W-1:0]          fetch_grp,
    input  logic                      trap_en,
    input  logic [GRP_W-1:0]          trap_num,
    input  logic [NG-1:0]             pend,
    input  logic [NG-1:0][IDX_W-1:0]  win,
    output logic [VA_W-1:0]           vec_addr,
    output logic                      vec_valid,
    output logic                      trap_illegal,
    output logic [NG-1:0]             clr_grp
);
    localparam int STRIDE  = 2 * GW;
    localparam int VEC_TOP = VEC_BASE + NG * STRIDE - 2;

    logic             hit;
    logic [IDX_W-1:0] sel_win;
    int               sel_k;

    always_comb begin
        hit     = 1'b0;
        sel_win = '0;
        sel_k   = 0;
        for (int k = 0; k < NG; k++) begin
            if (fetch_grp == GRP_W'(k + 1)) begin
                hit     = pend[k];
                sel_win = win[k];
                sel_k   = k;
            end
        end
    end

    always_comb begin
        vec_addr     = VA_W'(VEC_DFLT);
        vec_valid    = 1'b0;
        trap_illegal = 1'b0;
        clr_grp      = '0;
        if (en) begin
            if (fetch_en) begin
                if (hit) begin
                    vec_valid      = 1'b1;
                    vec_addr       = VA_W'(VEC_BASE + sel_k * STRIDE + 2 * int'(sel_win));
                    clr_grp[sel_k] = 1'b1;
                end
            end else if (trap_en) begin
                if (trap_num == '0) begin
                    trap_illegal = 1'b1;
                end else if (int'(trap_num) <= NG) begin
                    vec_valid = 1'b1;
                    vec_addr  = VA_W'(VEC_BASE + (int'(trap_num) - 1) * STRIDE);
                end
            end
        end
    end

    // R3: a valid vector is even and inside the table
    p_vec_in_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (int'(vec_addr) >= VEC_BASE && int'(vec_addr) <= VEC_TOP && !vec_addr[0]));
    // R7: trap 0 never yields a vector
    p_trap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && trap_en && !fetch_en && trap_num == '0) |-> (trap_illegal && !vec_valid));
    // R4: at most one group is consumed per fetch
    p_single_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_grp));
endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irq_exp_pkg::*;
#(
    parameter int NG       = 12,
    parameter int GW       = 8,
    parameter int VA_W     = 12,
    parameter int VEC_BASE = 'hD40,
    parameter int VEC_DFLT = 'h000,
    parameter int REG_BASE = 'h0CE0,
    localparam int NSRC    = NG * GW,
    localparam int IDX_W   = $clog2(GW),
    localparam int GRP_W   = $clog2(NG + 1),
    localparam int MAP_END = 2 + 2 * NG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_req,
    input  logic             reg_wr,
    input  logic [15:0]      reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [NG-1:0]    cpu_irq,
    input  logic             fetch_en,
    input  logic [GRP_W-1:0] fetch_grp,
    input  logic             trap_en,
    input  logic [GRP_W-1:0] trap_num,
    output logic [VA_W-1:0]  vec_addr,
    output logic             vec_valid,
    output logic             trap_illegal,
    input  logic             vt_wr_req,
    input  logic             vt_unlock,
    output logic             vt_wr_allow
);
    typedef struct packed {
        logic          en;
        logic [NG-1:0] ack;
    } top_st_t;

    top_st_t st_d, st_q;

    reg_kind_e              kind;
    logic [15:0]            off;
    logic [15:0]            gsel;
    logic [NG-1:0]          ena_we, flag_we, clr_grp, pend;
    logic                   ack_we;
    logic [NG-1:0][GW-1:0]  ena_v, flag_v;
    logic [NG-1:0][IDX_W-1:0] win_v;

    // address decode
    always_comb begin
        off  = reg_addr - 16'(REG_BASE);
        kind = RK_NONE;
        gsel = '0;
        if (reg_addr >= 16'(REG_BASE) && off < 16'(MAP_END)) begin
            if (off == 16'd0)      kind = RK_CTRL;
            else if (off == 16'd1) kind = RK_ACK;
            else begin
                kind = off[0] ? RK_FLAG : RK_ENA;
                gsel = (off - 16'd2) >> 1;
            end
        end
        ack_we = reg_wr && kind == RK_ACK;
        for (int k = 0; k < NG; k++) begin
            ena_we[k]  = reg_wr && kind == RK_ENA  && gsel == 16'(k);
            flag_we[k] = reg_wr && kind == RK_FLAG && gsel == 16'(k);
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (kind)
            RK_CTRL: reg_rdata = REG_W'(st_q.en);
            RK_ACK:  reg_rdata = REG_W'(st_q.ack);
            RK_ENA, RK_FLAG: begin
                for (int k = 0; k < NG; k++) begin
                    if (gsel == 16'(k))
                        reg_rdata = REG_W'(kind == RK_FLAG ? flag_v[k] : ena_v[k]);
                end
            end
            default: reg_rdata = '0;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < NG; g++) begin : g_grp
            irq_exp_group #(.GW(GW), .IDX_W(IDX_W)) u_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .src_req (src_req[g*GW +: GW]),
                .ena_we  (ena_we[g]),
                .flag_we (flag_we[g]),
                .wdata   (reg_wdata[GW-1:0]),
                .clr_win (clr_grp[g]),
                .ena_o   (ena_v[g]),
                .flag_o  (flag_v[g]),
                .pend_o  (pend[g]),
                .win_o   (win_v[g])
            );
        end
    endgenerate

    irq_exp_vector #(
        .NG(NG), .GW(GW), .IDX_W(IDX_W), .GRP_W(GRP_W), .VA_W(VA_W),
        .VEC_BASE(VEC_BASE), .VEC_DFLT(VEC_DFLT)
    ) u_vec (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (st_q.en),
        .fetch_en     (fetch_en),
        .fetch_grp    (fetch_grp),
        .trap_en      (trap_en),
        .trap_num     (trap_num),
        .pend         (pend),
        .win          (win_v),
        .vec_addr     (vec_addr),
        .vec_valid    (vec_valid),
        .trap_illegal (trap_illegal),
        .clr_grp      (clr_grp)
    );

    always_comb begin
        st_d    = st_q;
        if (reg_wr && kind == RK_CTRL) st_d.en = reg_wdata[0];
        st_d.ack = (st_q.ack & ~(ack_we ? reg_wdata[NG-1:0] : '0)) | clr_grp;
        for (int k = 0; k < NG; k++)
            cpu_irq[k] = st_q.en && !st_q.ack[k] && pend[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vt_wr_allow = vt_wr_req & vt_unlock;

    // R4: an accepted fetch sets the acknowledge bit of its group
    p_fetch_sets_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_grp != '0) |=> ((st_q.ack & $past(clr_grp)) == $past(clr_grp)));
    // R4: acknowledge bits only fall through a register write
    p_ack_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_we) |=> ((st_q.ack & $past(st_q.ack)) == $past(st_q.ack)));
    // R8: disabled block raises nothing
    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en) |-> (cpu_irq == '0 && !vec_valid && !trap_illegal));
    // R6: a trap alone leaves acknowledge state untouched
    p_trap_stateless_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_en && !fetch_en && !ack_we) |=> (st_q.ack == $past(st_q.ack)));
endmodule

// File: tb/irq_expander_tb.sv
`timescale 1ns/1ps
module irq_expander_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src_req = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [11:0] cpu_irq;
    logic        fetch_en = 1'b0;
    logic [3:0]  fetch_grp = '0;
    logic        trap_en = 1'b0;
    logic [3:0]  trap_num = '0;
    logic [11:0] vec_addr;
    logic        vec_valid;
    logic        trap_illegal;
    logic        vt_wr_req = 1'b0;
    logic        vt_unlock = 1'b0;
    logic        vt_wr_allow;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_expander u_dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_irq(cpu_irq), .fetch_en(fetch_en), .fetch_grp(fetch_grp),
        .trap_en(trap_en), .trap_num(trap_num), .vec_addr(vec_addr),
        .vec_valid(vec_valid), .trap_illegal(trap_illegal),
        .vt_wr_req(vt_wr_req), .vt_unlock(vt_unlock), .vt_wr_allow(vt_wr_allow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk); src_req[n] = 1'b1;
        @(negedge clk); src_req[n] = 1'b0;
    endtask

    task automatic fetch(input int g, output logic [11:0] a, output logic v);
        @(negedge clk); fetch_en = 1'b1; fetch_grp = 4'(g); #1; a = vec_addr; v = vec_valid;
        @(negedge clk); fetch_en = 1'b0;
    endtask

    task automatic trap(input int n, output logic [11:0] a, output logic v, output logic il);
        @(negedge clk); trap_en = 1'b1; trap_num = 4'(n); #1;
        a = vec_addr; v = vec_valid; il = trap_illegal;
        @(negedge clk); trap_en = 1'b0;
    endtask

    function automatic logic [15:0] ena_a(input int g); return 16'h0CE2 + 16'(2*(g-1)); endfunction
    function automatic logic [15:0] flg_a(input int g); return 16'h0CE3 + 16'(2*(g-1)); endfunction

    task automatic t_reset();
        logic [15:0] d;
        check("R2 reset irq", 32'(cpu_irq), 0);
        rd(16'h0CE0, d); check("R9 reset ctrl", 32'(d), 0);
        rd(16'h0CE1, d); check("R9 reset ack", 32'(d), 0);
        rd(flg_a(3), d); check("R9 reset flag", 32'(d), 0);
        wr(16'h0CE0, 16'h0001);
        rd(16'h0CE0, d); check("R9 ctrl readback", 32'(d), 1);
    endtask

    task automatic t_edge();
        logic [15:0] d;
        pulse(18);
        rd(flg_a(3), d); check("R1 edge sets flag while disabled", 32'(d), 32'h4);
        check("R2 no irq without enable bit", 32'(cpu_irq[2]), 0);
        wr(ena_a(3), 16'h0004);
        check("R2 irq once enabled", 32'(cpu_irq[2]), 1);
        wr(flg_a(3), 16'h0000);
        check("R2 irq drops with flag", 32'(cpu_irq[2]), 0);
        @(negedge clk); src_req[18] = 1'b1;
        @(negedge clk);
        wr(flg_a(3), 16'h0000);
        repeat (3) @(negedge clk);
        rd(flg_a(3), d); check("R1 held level not recaptured", 32'(d), 0);
        src_req[18] = 1'b0;
    endtask

    task automatic t_prio_ack();
        logic [15:0] d; logic [11:0] a; logic v;
        wr(ena_a(3), 16'h00FF);
        pulse(21); pulse(18);
        fetch(3, a, v);
        check("R3 lowest index wins addr", 32'(a), 32'hD64);
        check("R3 valid", 32'(v), 1);
        rd(16'h0CE1, d); check("R4 ack set by fetch", 32'(d), 32'h4);
        rd(flg_a(3), d); check("R4 winner cleared", 32'(d), 32'h20);
        check("R4 ack blocks pending group", 32'(cpu_irq[2]), 0);
        wr(16'h0CE1, 16'h0000);
        check("R4 writing 0 keeps ack", 32'(cpu_irq[2]), 0);
        wr(16'h0CE1, 16'h0004);
        check("R4 ack cleared reopens", 32'(cpu_irq[2]), 1);
        fetch(3, a, v);
        check("R3 second source addr", 32'(a), 32'hD6A);
        rd(flg_a(3), d); check("R4 flags empty", 32'(d), 0);
        wr(16'h0CE1, 16'h0004);
        wr(ena_a(3), 16'h0000);
    endtask

    task automatic t_rmw();
        logic [15:0] v0, d; logic [11:0] a; logic v;
        wr(ena_a(1), 16'h0003);
        rd(flg_a(1), v0);
        pulse(0);
        wr(flg_a(1), v0 | 16'h0002);
        rd(flg_a(1), d); check("R5 read-modify-write loses peripheral flag", 32'(d), 32'h2);
        check("R5 software flag raises irq", 32'(cpu_irq[0]), 1);
        fetch(1, a, v); check("R5 software vector", 32'(a), 32'hD42);
        wr(16'h0CE1, 16'h0001);
        wr(ena_a(1), 16'h0000);
    endtask

    task automatic t_quiet_groups();
        logic [11:0] a; logic v;
        int gs[3] = '{5, 7, 11};
        int ix[3] = '{8, 1, 4};
        for (int n = 0; n < 3; n++) begin
            wr(ena_a(gs[n]), 16'(1 << (ix[n]-1)));
            wr(flg_a(gs[n]), 16'(1 << (ix[n]-1)));
            check("R11 quiet group irq", 32'(cpu_irq[gs[n]-1]), 1);
            fetch(gs[n], a, v);
            check("R11 quiet group vector", 32'(a), 32'(12'hD40 + 16*(gs[n]-1) + 2*(ix[n]-1)));
            wr(16'h0CE1, 16'(1 << (gs[n]-1)));
            check("R11 quiet group consumed", 32'(cpu_irq[gs[n]-1]), 0);
        end
    endtask

    task automatic t_trap();
        logic [15:0] d0, d1; logic [11:0] a; logic v, il;
        wr(ena_a(4), 16'h0001); wr(flg_a(4), 16'h0001);
        rd(16'h0CE1, d0);
        trap(1, a, v, il);  check("R6 trap1 addr", 32'(a), 32'hD40); check("R6 trap1 valid", 32'(v), 1);
        trap(2, a, v, il);  check("R6 trap2 addr", 32'(a), 32'hD50);
        trap(12, a, v, il); check("R6 trap12 addr", 32'(a), 32'hDF0); check("R6 trap12 legal", 32'(il), 0);
        rd(16'h0CE1, d1); check("R6 trap leaves ack", 32'(d1), 32'(d0));
        rd(flg_a(4), d1); check("R6 trap leaves flags", 32'(d1), 1);
        trap(0, a, v, il);
        check("R7 trap0 illegal", 32'(il), 1); check("R7 trap0 no vector", 32'(v), 0);
        wr(flg_a(4), 16'h0000); wr(ena_a(4), 16'h0000);
    endtask

    task automatic t_disable();
        logic [15:0] d; logic [11:0] a; logic v, il;
        wr(ena_a(2), 16'h0001); wr(flg_a(2), 16'h0001);
        check("R2 enabled group raised", 32'(cpu_irq[1]), 1);
        wr(16'h0CE0, 16'h0000);
        check("R8 lines low when off", 32'(cpu_irq), 0);
        fetch(2, a, v); check("R8 fetch default addr", 32'(a), 0); check("R8 fetch invalid", 32'(v), 0);
        rd(flg_a(2), d); check("R8 flag kept when off", 32'(d), 1);
        trap(0, a, v, il); check("R8 trap0 not flagged when off", 32'(il), 0);
        wr(16'h0CE0, 16'h0001);
        check("R2 line returns on enable", 32'(cpu_irq[1]), 1);
        wr(flg_a(2), 16'h0000); wr(ena_a(2), 16'h0000);
    endtask

    task automatic t_map();
        logic [15:0] d;
        wr(16'h0CFA, 16'hFFFF);
        rd(16'h0CFA, d); check("R9 reserved reads 0", 32'(d), 0);
        rd(16'h0CFF, d); check("R9 reserved top reads 0", 32'(d), 0);
        rd(16'h0CE0, d); check("R9 reserved write ignored", 32'(d), 1);
        wr(16'h0CF8, 16'hFFFF);
        rd(16'h0CF8, d); check("R9 group12 enable width", 32'(d), 32'hFF);
        rd(16'h0CF9, d); check("R9 group12 flags untouched", 32'(d), 0);
        wr(16'h0CF8, 16'h0000);
    endtask

    task automatic t_protect();
        @(negedge clk); vt_wr_req = 1'b1; vt_unlock = 1'b0; #1;
        check("R10 locked write refused", 32'(vt_wr_allow), 0);
        vt_unlock = 1'b1; #1;
        check("R10 unlocked write allowed", 32'(vt_wr_allow), 1);
        vt_wr_req = 1'b0; #1;
        check("R10 no request no allow", 32'(vt_wr_allow), 0);
        vt_unlock = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_prio_ack();
        t_rmw();
        t_quiet_groups();
        t_trap();
        t_disable();
        t_map();
        t_protect();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule